// File: doc/BRIEF.md
# Memory fill and readback sequencer

The block is a self-running memory test controller. When the start request `go` is raised while it is idle, it writes a block of `WORDS` consecutive words into a single-port synchronous RAM, starting at address 0, with a data value that starts at zero and grows by a fixed additive step (0x04040404 by default) for every word. It then reads the same addresses back in the same order and compares each returned word with the regenerated pattern. It then raises `done` and holds it until `go` falls. This forms a level request/acknowledge handshake that software can poll through one input and one output line.

The sequencer is the only driver of the RAM's enable, write-enable, address and write-data inputs. It observes only the RAM's read data, which arrives one clock after the address. Any mismatch sets a sticky `error` flag, and `fail_addr` keeps the address of the first bad word. A separate synchronous soft reset returns the controller to idle at any point and clears its counters and its result. A small behavioural RAM model, `fill_check_ram`, is supplied with the block. Its output register updates, and resets, only while its enable is high.

Top module: `fill_check_seq`

## Requirements
- R1: During reset and while idle, `mem_en`, `mem_we` and `done` are 0, `mem_addr` and `mem_wdata` are 0, and `error` is 0 after reset. `mem_we` is never 1 while `mem_en` is 0.
- R2: On a clock edge that samples `go`=1 in idle, the write phase starts. For WORDS cycles it drives `mem_en`=1 and `mem_we`=1 with `mem_addr` = 0, 1, ..., WORDS-1, one address per cycle.
- R3: The word written at index i is i*STEP modulo 2^DW: 0 first, then each value is the previous one plus STEP.
- R4: Right after the last write, the read phase drives `mem_en`=1 and `mem_we`=0 for WORDS cycles with `mem_addr` = 0 .. WORDS-1. The read data for each address is taken one clock later.
- R5: A returned word that differs from its expected pattern sets `error`=1 and loads `fail_addr` with that word's address. Later mismatches change neither. `error` stays set until a soft reset or the next start from idle, which clears both.
- R6: `done` becomes 1 at the (2*WORDS+2)-th rising edge, counting as edge 1 the edge that samples `go`=1 in idle. `mem_en` is 0 while `done` is 1.
- R7: `done` and `error` hold while `go` stays 1. The first edge that samples `go`=0 returns the block to idle, with `done`=0 and `mem_en`=0.
- R8: `soft_rst`=1 returns the block to idle on the next edge from any phase. It reloads the address and data to 0 and clears `error` and `fail_addr`. It wins over `go` on that edge. With `go` still 1 afterwards, a new write phase starts at address 0 with data 0.
- R9: The RAM model returns the stored word one clock after the address is presented, and updates its output only while `en`=1. Its `rst`=1 clears the output only while `en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the RAM |
| rst | input | 1 | Synchronous system reset, active high |
| go | input | 1 | Level start request |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| done | output | 1 | Run finished, held until `go` falls |
| error | output | 1 | Sticky readback mismatch flag |
| fail_addr | output | AW | Address of the first mismatching word |
| mem_en | output | 1 | RAM enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | AW | RAM word address |
| mem_wdata | output | DW | RAM write data |
| mem_rdata | input | DW | RAM read data, one clock after the address |

## Verification
Clean runs with random idle gaps and random hold times before `go` is released show whether the write order, the step pattern, the read order and the fixed completion latency are right. Read data is corrupted between the RAM and the block from a chosen address onward, including the first word and the last word. These runs show whether the one-cycle read alignment is right, because the last word is compared only after the read phase has ended, and whether only the first failing address is kept. Soft resets during writes, during reads and while `done` is held show whether the soft reset takes priority over a held `go` and restarts the pattern cleanly. A second RAM instance is exercised directly for its enable-gated latency and reset.

// File: rtl/fill_check_ram.sv
module fill_check_ram #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      if (rst) rdata <= '0;
      else     rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/fill_check_seq.sv
module fill_check_seq #(
  parameter int            WORDS = 1024,
  parameter int            AW    = 10,
  parameter int            DW    = 32,
  parameter logic [DW-1:0] STEP  = 32'h0404_0404
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          soft_rst,
  output logic          done,
  output logic          error,
  output logic [AW-1:0] fail_addr,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  typedef enum logic [2:0] {S_IDLE, S_WR, S_RD, S_FLUSH, S_DONE} st_t;

  st_t           st;
  logic [AW-1:0] cnt, chk_addr;
  logic [DW-1:0] pat, chk_exp;
  logic          chk_vld;

  assign mem_en    = (st == S_WR) || (st == S_RD);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = cnt;
  assign mem_wdata = pat;
  assign done      = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      st        <= S_IDLE;
      cnt       <= '0;
      pat       <= '0;
      chk_vld   <= 1'b0;
      chk_exp   <= '0;
      chk_addr  <= '0;
      error     <= 1'b0;
      fail_addr <= '0;
    end else begin
      chk_vld  <= (st == S_RD);
      chk_exp  <= pat;
      chk_addr <= cnt;
      if (chk_vld && mem_rdata != chk_exp && !error) begin
        error     <= 1'b1;
        fail_addr <= chk_addr;
      end
      case (st)
        S_IDLE: if (go) begin
          st        <= S_WR;
          error     <= 1'b0;
          fail_addr <= '0;
        end
        S_WR, S_RD: begin
          if (cnt == LAST) begin
            st  <= (st == S_WR) ? S_RD : S_FLUSH;
            cnt <= '0;
            pat <= '0;
          end else begin
            cnt <= cnt + 1'b1;
            pat <= pat + STEP;
          end
        end
        S_FLUSH: st <= S_DONE;
        S_DONE:  if (!go) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fill_check_seq_chk.sv
module fill_check_seq_chk #(
  parameter int            AW   = 10,
  parameter int            DW   = 32,
  parameter logic [DW-1:0] STEP = 32'h0404_0404
) (
  input logic          clk,
  input logic          rst,
  input logic          go,
  input logic          soft_rst,
  input logic          done,
  input logic          error,
  input logic          mem_en,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata
);
  // R1
  we_needs_en_chk: assert property (@(posedge clk) disable iff (rst) mem_we |-> mem_en);
  // R2
  wr_addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> mem_addr == AW'($past(mem_addr) + 1'b1));
  // R3
  wr_data_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> mem_wdata == DW'($past(mem_wdata) + STEP));
  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (error && !go && !soft_rst) |=> error);
  // R6
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst) done |-> !mem_en);
  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && go && !soft_rst) |=> done);
  // R7
  done_release_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !go && !soft_rst) |=> (!done && !mem_en));
  // R8
  srst_idle_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!mem_en && !done && !error && mem_addr == '0 && mem_wdata == '0));
endmodule

bind fill_check_seq fill_check_seq_chk #(.AW(AW), .DW(DW), .STEP(STEP)) u_chk (
  .clk(clk), .rst(rst), .go(go), .soft_rst(soft_rst), .done(done), .error(error),
  .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/test_fill_check_seq.sv
module test_fill_check_seq;
  localparam int            W    = 40;
  localparam int            AW   = 10;
  localparam int            DW   = 32;
  localparam logic [DW-1:0] STEP = 32'h0404_0404;

  logic clk = 1'b0, rst = 1'b1, go = 1'b0, soft_rst = 1'b0;
  always #4 clk = ~clk;

  logic          done, error, mem_en, mem_we;
  logic [AW-1:0] fail_addr, mem_addr;
  logic [DW-1:0] mem_wdata, ram_q, rd_in;

  logic          flip_on = 1'b0;
  logic [AW-1:0] flip_from = '0, rd_addr_q = '0;
  logic [DW-1:0] flip_mask = '0;

  fill_check_ram #(.AW(AW), .DW(DW)) i_ram (
    .clk(clk), .en(mem_en), .we(mem_we), .rst(rst), .addr(mem_addr),
    .wdata(mem_wdata), .rdata(ram_q));

  assign rd_in = ram_q ^ ((flip_on && rd_addr_q >= flip_from) ? flip_mask : '0);

  fill_check_seq #(.WORDS(W), .AW(AW), .DW(DW), .STEP(STEP)) i_fill_check_seq (
    .clk(clk), .rst(rst), .go(go), .soft_rst(soft_rst), .done(done), .error(error),
    .fail_addr(fail_addr), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(rd_in));

  logic          r_en = 1'b0, r_we = 1'b0, r_rst = 1'b0;
  logic [AW-1:0] r_addr = '0;
  logic [DW-1:0] r_wd = '0, r_q;
  fill_check_ram #(.AW(AW), .DW(DW)) i_ram2 (
    .clk(clk), .en(r_en), .we(r_we), .rst(r_rst), .addr(r_addr), .wdata(r_wd), .rdata(r_q));

  int checks = 0, errors = 0;
  int wr_idx = 0, rd_idx = 0, wr_bad = 0, rd_bad = 0, k_idx;
  bit prev_wr = 0, prev_rd = 0;

  function automatic logic [DW-1:0] pat_of(input int i);
    return DW'(i) * STEP;
  endfunction

  always @(posedge clk) if (mem_en && !mem_we) rd_addr_q <= mem_addr;

  always @(negedge clk) begin
    if (!rst && mem_en && mem_we) begin
      k_idx = prev_wr ? wr_idx : 0;
      if (mem_addr != AW'(k_idx) || mem_wdata != pat_of(k_idx)) wr_bad++;
      wr_idx = k_idx + 1;
    end
    if (!rst && mem_en && !mem_we) begin
      k_idx = prev_rd ? rd_idx : 0;
      if (mem_addr != AW'(k_idx)) rd_bad++;
      rd_idx = k_idx + 1;
    end
    prev_wr = mem_en && mem_we;
    prev_rd = mem_en && !mem_we;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input int pre, input bit corrupt, input int from,
                     input logic [DW-1:0] mask, input int hold);
    int wb0 = wr_bad, rb0 = rd_bad, n = 0;
    bit exp_err;
    flip_on = corrupt; flip_from = AW'(from); flip_mask = mask;
    repeat (pre) @(negedge clk);
    chk(!mem_en && !mem_we && !done, "R1", "idle quiet", {mem_en, mem_we, done}, 0);
    go = 1'b1;
    do begin @(negedge clk); n++; end while (!done && n < 6 * W);
    chk(n == 2 * W + 2, "R6", "done latency", n, 2 * W + 2);
    chk(wr_idx == W, "R2", "write count", wr_idx, W);
    chk(wr_bad == wb0, "R3", "write addr/pattern errors", wr_bad - wb0, 0);
    chk(rd_idx == W && rd_bad == rb0, "R4", "read count/order", rd_idx, W);
    exp_err = corrupt && mask != 0 && from < W;
    chk(error == exp_err, "R5", "error flag", error, exp_err);
    if (exp_err) chk(fail_addr == AW'(from), "R5", "first fail addr", fail_addr, from);
    repeat (hold) @(negedge clk);
    chk(done && error == exp_err && !mem_en, "R7", "done/error hold", {done, error}, {1'b1, exp_err});
    go = 1'b0;
    @(negedge clk);
    chk(!done && !mem_en, "R7", "release to idle", {done, mem_en}, 0);
    flip_on = 1'b0;
  endtask

  task automatic srst_at(input int k, input bit corrupt);
    int wb0, n = 1;
    flip_on = corrupt; flip_from = '0; flip_mask = 32'h1;
    go = 1'b1;
    repeat (k) @(negedge clk);
    if (k >= 2 * W + 2)
      chk(done && error == corrupt, "R5", "result before soft reset", {done, error}, {1'b1, corrupt});
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk(!mem_en && !done && !error && mem_addr == 0 && mem_wdata == 0, "R8", "soft reset to idle",
        {mem_en, done, error, mem_addr, mem_wdata}, 0);
    flip_on = 1'b0;
    wb0 = wr_bad;
    @(negedge clk);
    chk(mem_we && mem_addr == 0 && mem_wdata == 0, "R8", "restart at word 0",
        {mem_we, mem_addr, mem_wdata}, {1'b1, 42'h0});
    do begin @(negedge clk); n++; end while (!done && n < 6 * W);
    chk(n == 2 * W + 2 && !error && wr_bad == wb0, "R8", "clean run after soft reset", n, 2 * W + 2);
    go = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(20240611);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!mem_en && !mem_we && !done && !error && mem_addr == 0 && mem_wdata == 0, "R1", "reset state",
        {mem_en, mem_we, done, error, mem_addr, mem_wdata}, 0);

    run(1, 0, 0, '0, 2);
    run(2, 1, 0, 32'h8000_0000, 0);
    run(0, 1, W - 1, 32'h0000_0100, 3);
    run(1, 1, 7, 32'hFFFF_FFFF, 1);
    run(1, 0, 0, '0, 0);

    for (int i = 0; i < 8; i++) begin
      int pre = int'($urandom_range(0, 5));
      bit cor = 1'($urandom_range(0, 1));
      int frm = int'($urandom_range(0, W - 1));
      logic [DW-1:0] msk = $urandom() | 32'h1;
      int hld = int'($urandom_range(0, 6));
      run(pre, cor, frm, msk, hld);
    end

    srst_at(5, 0);
    srst_at(W + 3, 1);
    srst_at(2 * W + 4, 1);

    @(negedge clk);
    r_en = 1; r_we = 1; r_addr = 10'd5; r_wd = 32'hA5A5_0001;
    @(negedge clk);
    r_addr = 10'd6; r_wd = 32'h0000_1234;
    @(negedge clk);
    r_we = 0; r_addr = 10'd5;
    @(negedge clk);
    chk(r_q == 32'hA5A5_0001, "R9", "ram read latency", r_q, 32'hA5A5_0001);
    r_en = 0; r_addr = 10'd6;
    @(negedge clk);
    chk(r_q == 32'hA5A5_0001, "R9", "ram holds with en low", r_q, 32'hA5A5_0001);
    r_rst = 1;
    @(negedge clk);
    chk(r_q == 32'hA5A5_0001, "R9", "ram rst ignored with en low", r_q, 32'hA5A5_0001);
    r_en = 1;
    @(negedge clk);
    chk(r_q == 0, "R9", "ram rst with en high", r_q, 0);
    r_rst = 0;
    @(negedge clk);
    chk(r_q == 32'h0000_1234, "R9", "ram second word", r_q, 32'h0000_1234);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule